// File: doc/BRIEF.md
# Reset and Watchdog Supervisor Core

This block is the synchronous decision logic of a processor supervisor. It holds an active-low reset output asserted while the monitored rail is flagged as not good, or while a manual reset button is pressed. After every such cause goes away, it keeps the reset asserted for a programmable settling delay. Time is counted in ticks. A prescaler derives the ticks from the system clock, so the 100 ms delay and the 0.8 s watchdog period are set as tick counts. For simulation, the tick can be shortened to a few clocks.

A watchdog guards program execution. Software must change the level of the watchdog input, in either direction, before the time-out elapses. If it does not, the block issues a reset pulse of one full settling delay, and the watchdog then starts again from zero. A separate input marks the watchdog pin as left open. In that case the pin level is ignored and the block substitutes its own pattern: low for the first seven eighths of the period, then a one-tick high pulse. This pattern restarts the count, so an open pin never causes a time-out.

Top module: `rst_wdog_supervisor`

## Requirements
- R1: While the synchronized supply-good flag is low, `reset_n_o` is low.
- R2: After `supply_ok` rises, with the manual reset released, `reset_n_o` goes high exactly SYNC_STAGES + DELAY_TICKS*CLKS_PER_TICK clock edges after the input change. A drop of the flag during this delay restarts the delay from zero.
- R3: A fall of `supply_ok` drives `reset_n_o` low SYNC_STAGES+1 edges later, without waiting for any delay.
- R4: A low level on `mrst_n` drives `reset_n_o` low SYNC_STAGES+1 edges later, and it stays low while `mrst_n` stays low.
- R5: After `mrst_n` returns high, `reset_n_o` stays low for the full delay: SYNC_STAGES + DELAY_TICKS*CLKS_PER_TICK edges.
- R6: With the pin driven (not floating) and no level change on it, `reset_n_o` falls exactly WD_TICKS*CLKS_PER_TICK edges after reset was released.
- R7: A rising level change and a falling level change on `wd_in` each restart the watchdog. After the last change, the time-out fires SYNC_STAGES+1+WD_TICKS*CLKS_PER_TICK edges later. Changes spaced below the period keep `reset_n_o` high.
- R8: A watchdog time-out holds `reset_n_o` low for exactly DELAY_TICKS*CLKS_PER_TICK edges. The watchdog is held at zero during that reset, so the next time-out comes WD_TICKS*CLKS_PER_TICK edges after release.
- R9: While `wd_float` is high, `wd_in` has no effect and no time-out occurs, because the internal low-then-pulse pattern restarts the count at 7/8 of the period.
- R10: While `rst_n` is low, `reset_n_o` is low and all counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| supply_ok | input | 1 | Rail-above-threshold flag, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, asynchronous |
| wd_in | input | 1 | Watchdog service input, asynchronous |
| wd_float | input | 1 | High when the watchdog pin is left open |
| reset_n_o | output | 1 | Active-low reset to the processor |

## Verification
A wrong delay or watchdog count shows up as a release or time-out edge off by whole ticks. It appears in the first reset cycle after power-up, so the bench measures every edge to the exact clock. A watchdog that is not cleared during reset, or that misses one edge direction, shows up one period later as an early or unexpected time-out. A flaw in the open-pin pattern appears within one period as a spurious reset during a long window with the pin floating.

// File: rtl/sup_pkg.sv
package sup_pkg;
   // Bundle of the asynchronous inputs after synchronization
   typedef struct packed {
      logic ok;
      logic mr_n;
      logic wd;
      logic flt;
   } sup_in_t;

   localparam sup_in_t SUP_IN_INIT = '{ok: 1'b0, mr_n: 1'b1, wd: 1'b0, flt: 1'b0};

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_tick.sv
module sup_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   import sup_pkg::*;
   localparam int PW = cnt_width(DIV);

   if (DIV == 1) begin : g_direct
      assign tick = !clr;
   end else begin : g_count
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk) begin
         if (!rst_n || clr)     pcnt <= '0;
         else if (pcnt == LAST) pcnt <= '0;
         else                   pcnt <= pcnt + 1'b1;
      end
      assign tick = (pcnt == LAST) && !clr;
   end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
   parameter int CLKS_PER_TICK = 4,
   parameter int WD_TICKS      = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic wd_s,
   input  logic flt_s,
   output logic expire
);
   import sup_pkg::*;
   localparam int            WW     = cnt_width(WD_TICKS);
   localparam logic [WW-1:0] LAST   = WW'(WD_TICKS - 1);
   localparam logic [WW-1:0] FLT_AT = WW'((WD_TICKS * 7) / 8);

   logic [WW-1:0] wcnt;
   logic          eff, eff_q, edge_det, tick;

   // Open pin: low, then one high tick at 7/8 of the period
   assign eff      = flt_s ? (wcnt == FLT_AT) : wd_s;
   assign edge_det = eff ^ eff_q;

   always_ff @(posedge clk) begin
      if (!rst_n) eff_q <= 1'b0;
      else        eff_q <= eff;
   end

   sup_tick #(.DIV(CLKS_PER_TICK)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (hold | edge_det),
      .tick (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || hold || edge_det) wcnt <= '0;
      else if (tick) begin
         if (wcnt == LAST) wcnt <= '0;
         else              wcnt <= wcnt + 1'b1;
      end
   end

   assign expire = tick && (wcnt == LAST);

   // R7: any level change restarts the count
   p_edge_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_det |=> (wcnt == '0));
   // R8: counter pinned at zero during reset
   p_held_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (wcnt == '0));
   // R9: open pin pattern restarts before expiry
   p_float_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_s && $past(flt_s) && !hold && wcnt == FLT_AT) |=> (wcnt == '0));
endmodule

// File: rtl/rst_wdog_supervisor.sv
module rst_wdog_supervisor #(
   parameter int CLKS_PER_TICK = 50000,
   parameter int DELAY_TICKS   = 100,
   parameter int WD_TICKS      = 800,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic mrst_n,
   input  logic wd_in,
   input  logic wd_float,
   output logic reset_n_o
);
   import sup_pkg::*;
   localparam int            DW    = cnt_width(DELAY_TICKS);
   localparam logic [DW-1:0] DLAST = DW'(DELAY_TICKS - 1);

   if (DELAY_TICKS < 1) begin : g_bad_delay
      $error("DELAY_TICKS must be at least 1");
   end
   if (WD_TICKS < 8) begin : g_bad_wd
      $error("WD_TICKS must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CLKS_PER_TICK < 1) begin : g_bad_div
      $error("CLKS_PER_TICK must be at least 1");
   end

   sup_in_t raw, syn;
   logic    hold, dly_tick, wd_expire, rst_q;
   logic [DW-1:0] dcnt;

   assign raw = '{ok: supply_ok, mr_n: mrst_n, wd: wd_in, flt: wd_float};

   sup_sync #(.W($bits(sup_in_t)), .STAGES(SYNC_STAGES), .RST_VAL(SUP_IN_INIT)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw),
      .q    (syn)
   );

   assign hold = !syn.ok || !syn.mr_n || wd_expire;

   sup_tick #(.DIV(CLKS_PER_TICK)) u_dly_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (hold),
      .tick (dly_tick)
   );

   sup_wdog #(.CLKS_PER_TICK(CLKS_PER_TICK), .WD_TICKS(WD_TICKS)) u_wdog (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (rst_q),
      .wd_s  (syn.wd),
      .flt_s (syn.flt),
      .expire(wd_expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || hold) begin
         rst_q <= 1'b1;
         dcnt  <= '0;
      end else if (rst_q && dly_tick) begin
         if (dcnt == DLAST) begin
            rst_q <= 1'b0;
            dcnt  <= '0;
         end else begin
            dcnt  <= dcnt + 1'b1;
         end
      end
   end

   assign reset_n_o = !rst_q;

   p_low_while_bad_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !syn.ok |=> !reset_n_o);
   p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reset_n_o) |-> $past(dly_tick));
   p_drop_immediate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(syn.ok) |=> !reset_n_o);
   p_manual_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !syn.mr_n |=> !reset_n_o);
   p_timeout_asserts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wd_expire |=> !reset_n_o);
   p_no_expire_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !reset_n_o |-> !wd_expire);
endmodule

// File: tb/test_rst_wdog_supervisor.sv
module test_rst_wdog_supervisor;
   localparam int CPT = 4;
   localparam int D   = 5;
   localparam int W   = 16;
   localparam int S   = 2;

   localparam int LAT_REL  = S + D * CPT;
   localparam int LAT_ON   = S + 1;
   localparam int LAT_KICK = S + 1 + W * CPT;
   localparam int T_HIGH   = W * CPT;
   localparam int T_LOW    = D * CPT;

   logic clk = 1'b0, rst_n = 1'b0;
   logic supply_ok = 1'b0, mrst_n = 1'b1, wd_in = 1'b0, wd_float = 1'b0;
   logic reset_n_o;
   int   errors = 0, checks = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   rst_wdog_supervisor #(.CLKS_PER_TICK(CPT), .DELAY_TICKS(D), .WD_TICKS(W), .SYNC_STAGES(S))
   i_rst_wdog_supervisor (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mrst_n(mrst_n),
      .wd_in(wd_in), .wd_float(wd_float), .reset_n_o(reset_n_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Count posedges until reset_n_o equals lvl (sampled after each edge)
   task automatic meas(input logic lvl, output int n);
      n = 0;
      do begin
         @(posedge clk); #1;
         n++;
      end while (reset_n_o !== lvl && n < 400);
   endtask

   // Check reset_n_o stays at lvl for cyc cycles
   task automatic hold_chk(input logic lvl, input int cyc, input string tag);
      int bad = 0;
      for (int i = 0; i < cyc; i++) begin
         @(posedge clk); #1;
         if (reset_n_o !== lvl) bad++;
      end
      chk(bad == 0, tag, bad, 0);
   endtask

   initial begin
      int n;
      // R10: block reset
      repeat (5) @(posedge clk);
      #1 chk(reset_n_o === 1'b0, "R10 reset state", reset_n_o, 0);
      @(negedge clk) rst_n = 1'b1;

      // R1: supply not good
      hold_chk(1'b0, 100, "R1 low while supply bad");

      // R2: release delay
      @(negedge clk) supply_ok = 1'b1;
      meas(1'b1, n);
      chk(n == LAT_REL, "R2 release latency", n, LAT_REL);

      // R6 / R8: idle watchdog time-outs
      meas(1'b0, n);
      chk(n == T_HIGH, "R6 idle time-out", n, T_HIGH);
      meas(1'b1, n);
      chk(n == T_LOW, "R8 time-out pulse width", n, T_LOW);
      meas(1'b0, n);
      chk(n == T_HIGH, "R8 restart from zero", n, T_HIGH);
      meas(1'b1, n);
      chk(n == T_LOW, "R8 second pulse width", n, T_LOW);

      // R7: kick sweep keeps reset high
      for (int g = 10; g <= 60; g += 10) begin
         for (int k = 0; k < 3; k++) begin
            int bad = 0;
            for (int i = 0; i < g; i++) begin
               @(negedge clk);
               if (reset_n_o !== 1'b1) bad++;
            end
            wd_in = ~wd_in;
            chk(bad == 0, "R7 kick gap keeps reset high", bad, 0);
         end
      end
      // R7: rising change, exact time-out
      @(negedge clk) wd_in = 1'b0;
      repeat (20) @(negedge clk);
      wd_in = 1'b1;
      meas(1'b0, n);
      chk(n == LAT_KICK, "R7 rising kick time-out", n, LAT_KICK);
      meas(1'b1, n);
      // R7: falling change
      repeat (20) @(negedge clk);
      wd_in = 1'b0;
      meas(1'b0, n);
      chk(n == LAT_KICK, "R7 falling kick time-out", n, LAT_KICK);
      meas(1'b1, n);
      chk(n == T_LOW, "R8 pulse after kick time-out", n, T_LOW);

      // R9: open pin, wd_in toggling is ignored, no time-out
      @(negedge clk) wd_float = 1'b1;
      for (int i = 0; i < 6; i++) begin
         repeat (100) @(negedge clk);
         wd_in = ~wd_in;
         chk(reset_n_o === 1'b1, "R9 no time-out while floating", reset_n_o, 1);
      end
      hold_chk(1'b1, 300, "R9 long floating window");
      @(negedge clk) wd_float = 1'b0;
      meas(1'b0, n);
      chk(n <= LAT_KICK, "R9 driven again times out", n, LAT_KICK);
      meas(1'b1, n);

      // R3: supply drop is immediate
      repeat (10) @(negedge clk);
      supply_ok = 1'b0;
      meas(1'b0, n);
      chk(n == LAT_ON, "R3 drop latency", n, LAT_ON);
      hold_chk(1'b0, 40, "R1 held while dropped");
      @(negedge clk) supply_ok = 1'b1;
      meas(1'b1, n);
      chk(n == LAT_REL, "R2 release after drop", n, LAT_REL);
      // R2: drop during delay restarts it
      @(negedge clk) supply_ok = 1'b0;
      repeat (8) @(negedge clk);
      supply_ok = 1'b1;
      repeat (10) @(negedge clk);
      supply_ok = 1'b0;
      chk(reset_n_o === 1'b0, "R2 still low mid-delay", reset_n_o, 0);
      repeat (5) @(negedge clk);
      supply_ok = 1'b1;
      meas(1'b1, n);
      chk(n == LAT_REL, "R2 restarted delay", n, LAT_REL);

      // R4 / R5: manual reset
      repeat (10) @(negedge clk);
      mrst_n = 1'b0;
      meas(1'b0, n);
      chk(n == LAT_ON, "R4 manual assert latency", n, LAT_ON);
      hold_chk(1'b0, 80, "R4 held while pressed");
      @(negedge clk) mrst_n = 1'b1;
      meas(1'b1, n);
      chk(n == LAT_REL, "R5 manual release delay", n, LAT_REL);

      // R10: block reset forces reset low
      @(negedge clk) rst_n = 1'b0;
      @(posedge clk); #1;
      chk(reset_n_o === 1'b0, "R10 block reset asserts", reset_n_o, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule